// File: doc/BRIEF.md
# Add/Subtract/Negate Unit with Condition Flags

This block is a combinational integer unit that adds two operands, subtracts one from the other, or negates the second operand. It works on raw bit patterns. The same result word therefore serves both signed and unsigned callers. Four condition flags report how each view of the result should be read: negative, zero, carry (unsigned overflow, or no-borrow on subtract) and signed overflow.

The flags computed from the current operation appear combinationally. A copy of them is held in a flag register. That register loads on a rising clock edge only when the flag-update enable is high, so the caller chooses which operations leave their mark.

Top module: `addsub_flags`

## Requirements
- R1: Operation select `op` is 2 bits: 00 gives `a + b`, 01 gives `a - b`, 10 gives `0 - b`. Each result is the low WIDTH bits (default 32) of the arithmetic.
- R2: The reserved code 11 drives `result` to zero. It also drives all four combinational flags to zero, and it never changes the flag register, even while `set_flags` is high.
- R3: `flag_n` equals the most significant bit of `result`. `flag_z` is 1 exactly when every bit of `result` is 0.
- R4: For add, `flag_c` is the carry out of the top bit. For subtract and negate, the unit computes `x + ~y + 1` (with x = a, or x = 0 for negate) and `flag_c` is the carry out of that sum. So C=1 means no borrow occurred.
- R5: `flag_v` is the XOR of the carry into the top bit and the carry out of it. For add, V is 1 exactly when the two operands share a sign bit and the result's sign bit differs. Example: 0x7FFFFFFF + 0x7FFFFFFF gives 0xFFFFFFFE with V=1 and C=0.
- R6: For subtract, V can be 1 only when the operand sign bits differ.
- R7: For negate, V is 1 only when `b` is the most negative value (0x80000000).
- R8: Packed as `flags_q` = {N,Z,C,V}, bit 3 = N and bit 0 = V, the register loads {N,Z,C,V} on a rising edge when `set_flags` is high and `op` is not 11. Otherwise it holds its value.
- R9: `rst` is synchronous and active high, and it clears `flags_q` to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation select |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| set_flags | input | 1 | Flag register load enable |
| result | output | WIDTH | Arithmetic result |
| flag_n | output | 1 | Negative flag (combinational) |
| flag_z | output | 1 | Zero flag (combinational) |
| flag_c | output | 1 | Carry flag (combinational) |
| flag_v | output | 1 | Signed overflow flag (combinational) |
| flags_q | output | 4 | Registered {N,Z,C,V} |

## Verification
The main sweep crosses every pair of the boundary values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, plus a few mid-range words, under every operation code. This separates signed overflow from unsigned carry, and the no-borrow sense of carry on subtract.

A 33-bit reference model in the bench gives the expected result and carry. It derives overflow from operand and result signs, not from internal carries. A pseudo-random pass adds variety beyond the boundary values.

Register tests change operands while the enable is low and while the reserved code is presented, then read `flags_q`. This confirms that the register holds its value and reloads only under the enable.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic [3:0]       flags_q
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_NEG = 2'b10;
  localparam logic [1:0] OP_RSV = 2'b11;
  localparam int MSB = WIDTH - 1;

  logic             invert, valid;
  logic [WIDTH-1:0] x, y;
  logic [MSB-1:0]   low_sum;
  logic             c_into_msb, msb_sum, c_out;

  assign valid  = (op != OP_RSV);
  assign invert = (op == OP_SUB) || (op == OP_NEG);
  assign x      = (op == OP_NEG) ? '0 : a;
  assign y      = invert ? ~b : b;

  assign {c_into_msb, low_sum} = {1'b0, x[MSB-1:0]} + {1'b0, y[MSB-1:0]} + {{(WIDTH-1){1'b0}}, invert};
  assign {c_out, msb_sum}      = {1'b0, x[MSB]} + {1'b0, y[MSB]} + {1'b0, c_into_msb};

  assign result = valid ? {msb_sum, low_sum} : '0;
  assign flag_n = result[MSB];
  assign flag_z = valid && (result == '0);
  assign flag_c = valid && c_out;
  assign flag_v = valid && (c_out ^ c_into_msb);

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= 4'b0000;
    else if (set_flags && valid)
      flags_q <= {flag_n, flag_z, flag_c, flag_v};
  end

  // R2
  reserved_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSV) |-> (result == '0 && !flag_c && !flag_v));

  // R2
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSV) |=> $stable(flags_q));

  // R5
  add_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |-> (flag_v == ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB]))));

  // R6
  sub_same_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB && a[MSB] == b[MSB]) |-> !flag_v);

  // R7
  neg_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NEG) |-> (flag_v == (b == {1'b1, {(WIDTH-1){1'b0}}})));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> $stable(flags_q));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (set_flags && valid) |=> (flags_q == {$past(flag_n), $past(flag_z), $past(flag_c), $past(flag_v)}));

  // R9
  always_ff @(posedge clk) begin
    if ($past(rst) && !rst)
      reset_clear_chk: assert (flags_q == 4'b0000);
  end
endmodule

// File: tb/test_addsub_flags.sv
module test_addsub_flags;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   op;
  logic [W-1:0] a, b;
  logic         set_flags;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;
  logic [3:0]   flags_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flags #(.WIDTH(W)) i_addsub_flags (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .set_flags(set_flags),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .flags_q(flags_q)
  );

  function automatic logic [W+3:0] model(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    logic n, z, c, v;
    case (o)
      2'b00: begin
        s = {1'b0, x} + {1'b0, y};
        v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      2'b01: begin
        s = {1'b0, x} + {1'b0, ~y} + 33'd1;
        v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
      end
      2'b10: begin
        s = {1'b0, ~y} + 33'd1;
        v = (y == 32'h8000_0000);
      end
      default: begin
        s = '0;
        v = 1'b0;
      end
    endcase
    n = s[W-1];
    z = (o != 2'b11) && (s[W-1:0] == '0);
    c = (o != 2'b11) && s[W];
    return {s[W-1:0], n, z, c, v};
  endfunction

  task automatic check(input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
    end
  endtask

  task automatic try_comb(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W+3:0] e;
    op = o; a = x; b = y;
    #1;
    e = model(o, x, y);
    check(o == 2'b11 ? "R2" : "R1 R3 R4 R5 R6 R7", {result, flag_n, flag_z, flag_c, flag_v}, e);
  endtask

  logic [W-1:0] vals [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h4000_0000, 32'h1234_5678, 32'hC000_0001};

  initial begin
    logic [W+3:0] e;
    logic [3:0] saved;
    rst = 1; set_flags = 0; op = 0; a = 0; b = 0;
    @(posedge clk); @(posedge clk);
    #2 rst = 0;
    // R9 reset state
    check("R9", {{W{1'b0}}, flags_q}, {{W{1'b0}}, 4'b0000});

    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          try_comb(o[1:0], vals[i], vals[j]);

    // R5 named corners
    try_comb(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R5", {{W{1'b0}}, flag_c, flag_v}, {{W{1'b0}}, 2'b01});
    try_comb(2'b00, 32'h4000_0000, 32'h4000_0000);
    check("R5", {{W+2{1'b0}}, flag_v}, {{W+2{1'b0}}, 1'b1});
    // R7
    try_comb(2'b10, 32'h0, 32'h8000_0000);
    check("R7", {{W+2{1'b0}}, flag_v}, {{W+2{1'b0}}, 1'b1});

    for (int k = 0; k < 3000; k++)
      try_comb(2'($urandom_range(0, 3)), $urandom, $urandom);

    // R8 load
    @(negedge clk);
    op = 2'b01; a = 32'h5; b = 32'h5; set_flags = 1;
    e = model(2'b01, 32'h5, 32'h5);
    @(negedge clk);
    check("R8", {{W{1'b0}}, flags_q}, {{W{1'b0}}, e[3:0]});
    saved = flags_q;
    // R8 hold with enable low
    set_flags = 0; op = 2'b00; a = 32'h8000_0000; b = 32'h8000_0000;
    @(negedge clk); @(negedge clk);
    check("R8", {{W{1'b0}}, flags_q}, {{W{1'b0}}, saved});
    // R2 reserved with enable high keeps the register
    set_flags = 1; op = 2'b11;
    @(negedge clk);
    check("R2", {{W{1'b0}}, flags_q}, {{W{1'b0}}, saved});
    // R8 reload
    op = 2'b00;
    e = model(2'b00, 32'h8000_0000, 32'h8000_0000);
    @(negedge clk);
    check("R8", {{W{1'b0}}, flags_q}, {{W{1'b0}}, e[3:0]});
    // R9 reset again
    rst = 1;
    @(negedge clk);
    rst = 0; set_flags = 0;
    check("R9", {{W{1'b0}}, flags_q}, {{W{1'b0}}, 4'b0000});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule